// File: doc/BRIEF.md
# Receiver Bring-Up Sequencer

This block orders the start-up of a source-synchronous serial receiver. It owns the reset controls of an external clock-multiplying PLL and of the receiver datapath. It also owns two short clearing pulses, one for the receive FIFO and one for the bit-slip circuit, and a request that tells external word-alignment logic to begin. As inputs it takes the PLL lock flag, the phase-aligner lock flag and a completion flag from the word aligner. The PLL, the phase aligner and the word aligner all sit outside the block.

After reset, or after a restart request, the block holds both resets for a minimum time and then releases the PLL. It waits until the PLL lock flag has stayed high long enough to be trusted, and then releases the receiver. It then waits, within a time limit, for the phase aligner to lock while training data arrives. Once that lock is seen, it pulses the FIFO clear and then the slip clear, requests word alignment, and reports ready when the aligner signals completion. If the PLL drops lock once the receiver is out of reset, the whole sequence starts over. If the phase-aligner wait runs out, the block raises an error flag and also starts over.

Top module: `rx_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pll_rst` and `rx_rst` are 1 and `fifo_rst`, `slip_rst`, `align_start`, `ready` and `dpa_timeout_err` are 0.
- R2: Every hold phase keeps `pll_rst` and `rx_rst` at 1 for exactly `PLL_HOLD_CYC` cycles. Then `pll_rst` goes to 0 while `rx_rst` stays 1.
- R3: `rx_rst` falls only after `pll_lock` has been sampled high on `LOCK_STABLE_CYC` consecutive clock edges while the PLL is released. It falls on the edge that follows. A single low sample restarts the count.
- R4: If `dpa_lock` stays low for `DPA_TIMEOUT_CYC` cycles after `rx_rst` falls, then on that cycle's edge `dpa_timeout_err` goes to 1 and a new hold phase begins.
- R5: One edge after `dpa_lock` is sampled high while waiting for it, `fifo_rst` goes high for exactly `PULSE_CYC` cycles. `slip_rst` then goes high for exactly `PULSE_CYC` cycles. Neither pulse overlaps the other, and neither occurs while `rx_rst` is 1.
- R6: `align_start` rises directly after the slip pulse. It stays high until `align_done` is sampled high, and on the next edge `ready` rises and `align_start` falls.
- R7: Once `rx_rst` is 0, `pll_lock` sampled low starts a new hold phase on the next edge (`pll_rst` = 1, `rx_rst` = 1, `ready` = 0).
- R8: `restart_req` sampled high in any state starts a new hold phase on the next edge, with the hold length counted from that edge.
- R9: `dpa_timeout_err` stays set through the following hold phases. It clears when `ready` rises or when `restart_req` is sampled high.
- R10: At most one of `fifo_rst`, `slip_rst`, `align_start` and `ready` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_req | input | 1 | Request to rerun the bring-up from the hold phase |
| pll_lock | input | 1 | Lock flag from the external PLL |
| dpa_lock | input | 1 | Lock flag from the external phase aligner |
| align_done | input | 1 | Word boundaries found on every channel |
| pll_rst | output | 1 | Reset to the PLL, active high |
| rx_rst | output | 1 | Reset to the receiver datapath, active high |
| fifo_rst | output | 1 | Receive FIFO clear pulse |
| slip_rst | output | 1 | Bit-slip circuit clear pulse |
| align_start | output | 1 | Request to external word alignment |
| ready | output | 1 | Receiver is aligned and usable |
| dpa_timeout_err | output | 1 | Phase-aligner lock wait expired |

## Verification
The hardest case to reach is a lock glitch at every possible depth of the stability count. The bench therefore restarts the sequence once per glitch position. In each run it drops `pll_lock` for one edge after a chosen number of good samples, and it expects the receiver release exactly one qualifying count plus one edge after the lock returns. The phase-aligner timeout is the other hard case, because its window is long. The bench shrinks the window through a parameter, sweeps the lock arrival across it, and then runs past its end. It confirms that the error flag survives the automatic restart and clears only when the next run completes.

// File: rtl/rxb_pkg.sv
// Package: shared state encoding for the receiver bring-up sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package rxb_pkg;
    typedef enum logic [2:0] {
        ST_HOLD     = 3'd0,
        ST_PLL_WAIT = 3'd1,
        ST_DPA_WAIT = 3'd2,
        ST_FIFO_CLR = 3'd3,
        ST_SLIP_CLR = 3'd4,
        ST_ALIGN    = 3'd5,
        ST_READY    = 3'd6
    } seq_state_t;
endpackage

// File: rtl/rxb_lock_filter.sv
// Lock qualifier: counts consecutive high samples of a lock flag and reports
// it as stable once the count reaches STABLE_CYC. A low sample or clr resets
// the count. Assumes the lock flag is already synchronous to clk.
module rxb_lock_filter #(
    parameter int STABLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic lock_in,
    output logic stable
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive good samples, saturating at the target.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !lock_in) begin
            run_cnt <= '0;
        end else if (run_cnt != CW'(STABLE_CYC)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign stable = (run_cnt == CW'(STABLE_CYC));
endmodule

// File: rtl/rxb_step_timer.sv
// Phase timer: counts cycles spent in the current phase, saturating at its
// maximum value. clr starts the count again at zero on the next edge.
// Assumes the caller asserts clr on every phase change.
module rxb_step_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Advance once per cycle unless cleared or saturated.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt != {W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rx_bringup_seq.sv
// Receiver bring-up sequencer. It walks a fixed order: hold both resets, release
// the PLL, qualify its lock, release the receiver, wait for the phase aligner
// under a time limit, clear the FIFO, clear the slip circuit, request word
// alignment, report ready. A PLL lock loss after receiver release and a restart
// request both return it to the hold phase. Assumes all inputs are synchronous
// to clk and that the parameters are at least 1.
module rx_bringup_seq
    import rxb_pkg::*;
#(
    parameter int PLL_HOLD_CYC    = 8,
    parameter int LOCK_STABLE_CYC = 16,
    parameter int DPA_TIMEOUT_CYC = 4096,
    parameter int PULSE_CYC       = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_req,
    input  logic pll_lock,
    input  logic dpa_lock,
    input  logic align_done,
    output logic pll_rst,
    output logic rx_rst,
    output logic fifo_rst,
    output logic slip_rst,
    output logic align_start,
    output logic ready,
    output logic dpa_timeout_err
);
    localparam int TMAX_A = (PLL_HOLD_CYC > DPA_TIMEOUT_CYC) ? PLL_HOLD_CYC : DPA_TIMEOUT_CYC;
    localparam int TMAX   = (TMAX_A > PULSE_CYC) ? TMAX_A : PULSE_CYC;
    localparam int TW     = $clog2(TMAX + 1);
    localparam logic [TW-1:0] HOLD_LAST  = TW'(PLL_HOLD_CYC - 1);
    localparam logic [TW-1:0] TO_LAST    = TW'(DPA_TIMEOUT_CYC - 1);
    localparam logic [TW-1:0] PULSE_LAST = TW'(PULSE_CYC - 1);

    seq_state_t    st, st_nx;
    logic [TW-1:0] tcnt;
    logic          lock_ok;
    logic          lock_lost;
    logic          timeout_hit;
    logic          err_q;

    rxb_lock_filter #(.STABLE_CYC(LOCK_STABLE_CYC)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st == ST_HOLD),
        .lock_in (pll_lock),
        .stable  (lock_ok)
    );

    rxb_step_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((st_nx != st) || restart_req),
        .cnt   (tcnt)
    );

    // Flag lock loss only once the receiver has been released.
    assign lock_lost   = !pll_lock && (st != ST_HOLD) && (st != ST_PLL_WAIT);
    // Phase-aligner wait has run its full window without lock.
    assign timeout_hit = (st == ST_DPA_WAIT) && !dpa_lock && (tcnt == TO_LAST);

    // Next-state decode for the bring-up order, with restart taking precedence.
    always_comb begin
        st_nx = st;
        case (st)
            ST_HOLD:     if (tcnt == HOLD_LAST)  st_nx = ST_PLL_WAIT;
            ST_PLL_WAIT: if (lock_ok)            st_nx = ST_DPA_WAIT;
            ST_DPA_WAIT: if (dpa_lock)           st_nx = ST_FIFO_CLR;
                         else if (timeout_hit)   st_nx = ST_HOLD;
            ST_FIFO_CLR: if (tcnt == PULSE_LAST) st_nx = ST_SLIP_CLR;
            ST_SLIP_CLR: if (tcnt == PULSE_LAST) st_nx = ST_ALIGN;
            ST_ALIGN:    if (align_done)         st_nx = ST_READY;
            ST_READY:                            st_nx = ST_READY;
            default:                             st_nx = ST_HOLD;
        endcase
        if (lock_lost || restart_req) begin
            st_nx = ST_HOLD;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_HOLD;
        end else begin
            st <= st_nx;
        end
    end

    // Sticky timeout flag, cleared on a restart request or on reaching ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (timeout_hit) begin
            err_q <= 1'b1;
        end else if (restart_req || (st == ST_ALIGN && st_nx == ST_READY)) begin
            err_q <= 1'b0;
        end
    end

    assign pll_rst         = (st == ST_HOLD);
    assign rx_rst          = (st == ST_HOLD) || (st == ST_PLL_WAIT);
    assign fifo_rst        = (st == ST_FIFO_CLR);
    assign slip_rst        = (st == ST_SLIP_CLR);
    assign align_start     = (st == ST_ALIGN);
    assign ready           = (st == ST_READY);
    assign dpa_timeout_err = err_q;
endmodule

// File: rtl/rxb_seq_checker.sv
// Checker for the bring-up sequencer. It watches only the top-level ports and
// keeps one counter to measure the hold length. It is attached by bind below.
module rxb_seq_checker #(
    parameter int PLL_HOLD_CYC = 8
) (
    input logic clk,
    input logic rst_n,
    input logic pll_lock,
    input logic align_done,
    input logic pll_rst,
    input logic rx_rst,
    input logic fifo_rst,
    input logic slip_rst,
    input logic align_start,
    input logic ready,
    input logic dpa_timeout_err
);
    localparam int HW = $clog2(PLL_HOLD_CYC + 1) + 1;

    logic [HW-1:0] hold_run;

    // Length of the current run of PLL reset cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !pll_rst) begin
            hold_run <= '0;
        end else if (hold_run != {HW{1'b1}}) begin
            hold_run <= hold_run + 1'b1;
        end
    end

    a_r2_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst) |-> (hold_run >= HW'(PLL_HOLD_CYC)));
    a_r3_release_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_rst) |-> $past(pll_lock));
    a_r5_clear_outside_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rst || slip_rst) |-> !rx_rst);
    a_r5_slip_after_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slip_rst) |-> $past(fifo_rst));
    a_r6_ready_after_align: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(align_start && align_done));
    a_r7_lock_loss_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_rst && !pll_lock) |=> pll_rst);
    a_r9_ready_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !dpa_timeout_err);
    a_r10_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_rst, slip_rst, align_start, ready}));
endmodule

bind rx_bringup_seq rxb_seq_checker #(.PLL_HOLD_CYC(PLL_HOLD_CYC)) u_seq_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .pll_lock        (pll_lock),
    .align_done      (align_done),
    .pll_rst         (pll_rst),
    .rx_rst          (rx_rst),
    .fifo_rst        (fifo_rst),
    .slip_rst        (slip_rst),
    .align_start     (align_start),
    .ready           (ready),
    .dpa_timeout_err (dpa_timeout_err)
);

// File: tb/tb_rx_bringup_seq.sv
// Bench for the bring-up sequencer: sweeps of lock glitch position and
// phase-aligner lock arrival on a small configuration, with exact cycle counts.
module tb_rx_bringup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD   = 4;
    localparam int STABLE = 4;
    localparam int TOUT   = 20;
    localparam int PULSE  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart_req = 1'b0, pll_lock = 1'b0, dpa_lock = 1'b0, align_done = 1'b0;
    logic pll_rst, rx_rst, fifo_rst, slip_rst, align_start, ready, dpa_timeout_err;
    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    rx_bringup_seq #(
        .PLL_HOLD_CYC(HOLD), .LOCK_STABLE_CYC(STABLE),
        .DPA_TIMEOUT_CYC(TOUT), .PULSE_CYC(PULSE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .restart_req(restart_req), .pll_lock(pll_lock),
        .dpa_lock(dpa_lock), .align_done(align_done), .pll_rst(pll_rst),
        .rx_rst(rx_rst), .fifo_rst(fifo_rst), .slip_rst(slip_rst),
        .align_start(align_start), .ready(ready), .dpa_timeout_err(dpa_timeout_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock edge, then settle to the falling edge for sampling and driving.
    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Restart, run the hold phase, qualify lock, land in the first aligner-wait cycle.
    task automatic reach_dpa_wait();
        pll_lock = 1'b0; dpa_lock = 1'b0; align_done = 1'b0; restart_req = 1'b1;
        step();
        restart_req = 1'b0;
        check("R8 restart enters hold", {pll_rst, rx_rst, ready}, 3'b110);
        step(HOLD);
        check("R2 pll released after hold", {pll_rst, rx_rst}, 2'b01);
        pll_lock = 1'b1;
        step(STABLE + 1);
        check("R3 receiver released", {pll_rst, rx_rst}, 2'b00);
    endtask

    // From the aligner wait: lock after w cycles, check both pulses, align after a cycles.
    task automatic finish_bringup(input int w, input int a);
        step(w);
        check("R5 no clear pulse before aligner lock", {fifo_rst, slip_rst}, 2'b00);
        dpa_lock = 1'b1;
        for (int i = 0; i < PULSE; i++) begin
            step();
            check("R5 fifo pulse", {fifo_rst, slip_rst, align_start, rx_rst}, 4'b1000);
        end
        for (int i = 0; i < PULSE; i++) begin
            step();
            check("R5 slip pulse", {fifo_rst, slip_rst, align_start, rx_rst}, 4'b0100);
        end
        for (int i = 0; i <= a; i++) begin
            step();
            check("R6 align requested", {align_start, ready}, 2'b10);
        end
        align_done = 1'b1;
        step();
        check("R6 ready after align done", {align_start, ready}, 2'b01);
        check("R9 error clear at ready", dpa_timeout_err, 0);
        align_done = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        step(2);
        check("R1 reset outputs", {pll_rst, rx_rst, fifo_rst, slip_rst, align_start, ready, dpa_timeout_err}, 7'b1100000);
        rst_n = 1'b1;
        check("R1 first cycle after reset", {pll_rst, rx_rst}, 2'b11);
        step(HOLD - 1);
        check("R2 still holding", {pll_rst, rx_rst}, 2'b11);
        step();
        check("R2 hold length", {pll_rst, rx_rst}, 2'b01);

        // R3 sweep: glitch after d good samples (d = 0 means no glitch).
        for (int d = 0; d < STABLE; d++) begin
            pll_lock = 1'b0; restart_req = 1'b1;
            step();
            restart_req = 1'b0;
            step(HOLD);
            pll_lock = 1'b1;
            if (d > 0) begin
                step(d);
                pll_lock = 1'b0;
                step();
                check("R3 glitch keeps receiver in reset", rx_rst, 1);
                pll_lock = 1'b1;
            end
            step(STABLE);
            check("R3 not yet qualified", {pll_rst, rx_rst}, 2'b01);
            step();
            check("R3 qualified release", {pll_rst, rx_rst}, 2'b00);
        end

        // R4: aligner never locks.
        reach_dpa_wait();
        step(TOUT - 1);
        check("R4 before timeout", {rx_rst, dpa_timeout_err}, 2'b00);
        step();
        check("R4 timeout restarts", {pll_rst, rx_rst, dpa_timeout_err}, 3'b111);
        step(HOLD);
        check("R9 error held after hold", {pll_rst, dpa_timeout_err}, 2'b01);
        step(STABLE + 1);
        check("R9 error held in aligner wait", {rx_rst, dpa_timeout_err}, 2'b01);
        finish_bringup(3, 1);

        // R7: lock loss while ready.
        pll_lock = 1'b0;
        step();
        check("R7 lock loss from ready", {pll_rst, rx_rst, ready}, 3'b110);

        // R5/R6 sweep over aligner lock arrival and alignment delay.
        for (int w = 0; w <= TOUT - 2; w++) begin
            reach_dpa_wait();
            finish_bringup(w, w % 4);
        end

        // R7: lock loss during the aligner wait.
        reach_dpa_wait();
        step(2);
        pll_lock = 1'b0;
        step();
        check("R7 lock loss in aligner wait", {pll_rst, rx_rst}, 2'b11);

        // R9: restart clears a pending error.
        reach_dpa_wait();
        step(TOUT);
        check("R4 second timeout", dpa_timeout_err, 1);
        restart_req = 1'b1;
        step();
        restart_req = 1'b0;
        check("R9 restart clears error", dpa_timeout_err, 0);

        // R10 across a full run is held by the per-cycle patterns above.
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule